// File: doc/BRIEF.md
# Exception Event Queue with Host Read Port

This block collects single-word exception events from link hardware and holds them for a distant host processor. The host polls the queue through a command port. A single-read command returns the oldest queued event when one is waiting. When nothing is waiting, it returns a status word instead. Every response also reports the queue's read and write pointers, so the host learns the fill level from any read.

A burst command drains up to eight events with one request. It answers with a count header, followed by that many entries on consecutive cycles. Each response carries a kind code, so the host can tell the header from the entries. The interrupt line is raised only when the write pointer has moved past the last write pointer reported to the host. This keeps the host from being interrupted again for events it already knows about.

Top module: `evq_hostread`

## Requirements
- R1: A single read (`cmd_valid`=1, `cmd_burst`=0) on a non-empty queue gives, on the cycle after the command, `rsp_valid`=1, `rsp_kind`=0 (event) and the oldest event on `rsp_data`. The read pointer advances by one.
- R2: A single read on an empty queue gives `rsp_kind`=1 (status). `rsp_data` bit 31 holds the overflow flag, bits 7:0 hold `chan_state`, and all other bits are zero. The read pointer does not move.
- R3: Every response reports on `rsp_rdptr`/`rsp_wrptr` the 5-bit pointers after the command took effect. An event accepted in the same cycle is included in `rsp_wrptr`.
- R4: The queue holds 16 entries and returns them in arrival order. Pointers count modulo 32, and the fill level is the write pointer minus the read pointer.
- R5: An event offered while 16 entries are queued is discarded, and the overflow flag is set.
- R6: The overflow flag stays set until a status word is returned. The next status word then shows it cleared.
- R7: A burst command with count field N (4 bits) gives a header (`rsp_kind`=2) with M = min(N, 8, fill) in `rsp_data` bits 3:0. The header is followed by M entries (`rsp_kind`=3) in arrival order on consecutive cycles, and the read pointer advances by M.
- R8: Commands presented while a burst is still emitting entries are ignored and produce no response.
- R9: `irq` is high whenever the write pointer differs from the last write pointer returned in a response, and is low on every cycle that shows a response.
- R10: After reset, `rsp_valid`=0, `irq`=0 and both pointers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Event offered this cycle |
| evt_data | input | 32 | Event word |
| chan_state | input | 8 | Channel state placed in the status word |
| cmd_valid | input | 1 | Host command strobe |
| cmd_burst | input | 1 | 1 = burst read, 0 = single read |
| cmd_count | input | 4 | Requested entries for a burst |
| rsp_valid | output | 1 | Response word valid |
| rsp_kind | output | 2 | 0 event, 1 status, 2 burst header, 3 burst entry |
| rsp_data | output | 32 | Response word |
| rsp_rdptr | output | 5 | Read pointer after the command |
| rsp_wrptr | output | 5 | Write pointer after the command |
| irq | output | 1 | Host has not yet seen the newest write pointer |

## Verification
A short interleaved push/read table tells an event answer from a status answer, and checks that pointer reports and `irq` follow each step. Burst requests are exercised in three regimes: a request above eight, a request above the fill level, and a request on an empty queue. Together these separate the three limits on M. A command injected mid-burst shows whether the sequencer accepts work while busy. A full-queue push with a dropped event, followed by two empty reads, separates the sticky overflow flag from a flag that is cleared at once. A final pass drives the pointers through their modulo-32 wrap.

// File: rtl/evq_pkg.sv
package evq_pkg;
  typedef enum logic [1:0] {
    RSP_EVENT  = 2'd0,
    RSP_STATUS = 2'd1,
    RSP_HEADER = 2'd2,
    RSP_BENTRY = 2'd3
  } rsp_kind_e;
endpackage

// File: rtl/evq_store.sv
// Event storage: circular array with extra-bit pointers and sticky overflow.
module evq_store #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  input  logic          ovf_clr_i,
  output logic [AW:0]   rd_ptr_o,
  output logic [AW:0]   wr_ptr_o,
  output logic [AW:0]   rd_nxt_o,
  output logic [AW:0]   wr_nxt_o,
  output logic [AW:0]   fill_o,
  output logic [DW-1:0] head_o,
  output logic          ovf_o
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q, fill;
  logic          full, accept, ovf_q, ovf_d;

  always_comb begin
    fill     = wr_q - rd_q;
    full     = (fill == PW'(DEPTH));
    accept   = push_i & ~full;
    rd_nxt_o = rd_q + PW'(pop_i);
    wr_nxt_o = wr_q + PW'(accept);
    ovf_d    = (push_i & full) | (ovf_q & ~ovf_clr_i);
  end

  always_ff @(posedge clk) begin
    if (accept) mem_q[wr_q[AW-1:0]] <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      ovf_q <= 1'b0;
    end else begin
      rd_q  <= rd_nxt_o;
      wr_q  <= wr_nxt_o;
      ovf_q <= ovf_d;
    end
  end

  assign rd_ptr_o = rd_q;
  assign wr_ptr_o = wr_q;
  assign fill_o   = fill;
  assign head_o   = mem_q[rd_q[AW-1:0]];
  assign ovf_o    = ovf_q;
endmodule

// File: rtl/evq_reader.sv
// Command decode, burst sequencer and registered response word.
module evq_reader
  import evq_pkg::*;
#(
  parameter int DW   = 32,
  parameter int PW   = 5,
  parameter int CW   = 4,
  parameter int MAXB = 8,
  parameter int CSW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid_i,
  input  logic           cmd_burst_i,
  input  logic [CW-1:0]  cmd_count_i,
  input  logic [PW-1:0]  fill_i,
  input  logic [DW-1:0]  head_i,
  input  logic           ovf_i,
  input  logic [CSW-1:0] chan_state_i,
  input  logic [PW-1:0]  rd_nxt_i,
  input  logic [PW-1:0]  wr_nxt_i,
  output logic           pop_o,
  output logic           ovf_clr_o,
  output logic           emit_o,
  output logic           rsp_valid_o,
  output logic [1:0]     rsp_kind_o,
  output logic [DW-1:0]  rsp_data_o,
  output logic [PW-1:0]  rsp_rdptr_o,
  output logic [PW-1:0]  rsp_wrptr_o
);
  logic          busy_q, busy_d;
  logic [CW-1:0] rem_q, rem_d, req, grant;
  logic          take;
  rsp_kind_e     kind_d;
  logic [DW-1:0] data_d;
  logic [DW-1:0] status_word;

  always_comb begin
    take        = cmd_valid_i & ~busy_q;
    req         = (cmd_count_i > CW'(MAXB)) ? CW'(MAXB) : cmd_count_i;
    grant       = (PW'(req) < fill_i) ? req : CW'(fill_i);
    status_word = {ovf_i, {(DW-1-CSW){1'b0}}, chan_state_i};
    pop_o       = 1'b0;
    ovf_clr_o   = 1'b0;
    emit_o      = 1'b0;
    kind_d      = RSP_EVENT;
    data_d      = head_i;
    busy_d      = busy_q;
    rem_d       = rem_q;
    if (busy_q) begin
      emit_o = 1'b1;
      pop_o  = 1'b1;
      kind_d = RSP_BENTRY;
      rem_d  = rem_q - CW'(1);
      busy_d = (rem_q != CW'(1));
    end else if (take && !cmd_burst_i) begin
      emit_o = 1'b1;
      if (fill_i != '0) begin
        pop_o = 1'b1;
      end else begin
        kind_d    = RSP_STATUS;
        data_d    = status_word;
        ovf_clr_o = 1'b1;
      end
    end else if (take) begin
      emit_o = 1'b1;
      kind_d = RSP_HEADER;
      data_d = DW'(grant);
      rem_d  = grant;
      busy_d = (grant != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      rem_q       <= '0;
      rsp_valid_o <= 1'b0;
      rsp_kind_o  <= '0;
      rsp_data_o  <= '0;
      rsp_rdptr_o <= '0;
      rsp_wrptr_o <= '0;
    end else begin
      busy_q      <= busy_d;
      rem_q       <= rem_d;
      rsp_valid_o <= emit_o;
      if (emit_o) begin
        rsp_kind_o  <= kind_d;
        rsp_data_o  <= data_d;
        rsp_rdptr_o <= rd_nxt_i;
        rsp_wrptr_o <= wr_nxt_i;
      end
    end
  end
endmodule

// File: rtl/evq_irq.sv
// Remembers the write pointer last shown to the host.
module evq_irq #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [PW-1:0] wr_nxt_i,
  input  logic [PW-1:0] wr_ptr_i,
  output logic          irq_o
);
  logic [PW-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      seen_q <= '0;
    else if (load_i) seen_q <= wr_nxt_i;
  end

  assign irq_o = (wr_ptr_i != seen_q);
endmodule

// File: rtl/evq_hostread.sv
module evq_hostread #(
  parameter int DW   = 32,
  parameter int AW   = 4,
  parameter int CW   = 4,
  parameter int MAXB = 8,
  parameter int CSW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           evt_valid,
  input  logic [DW-1:0]  evt_data,
  input  logic [CSW-1:0] chan_state,
  input  logic           cmd_valid,
  input  logic           cmd_burst,
  input  logic [CW-1:0]  cmd_count,
  output logic           rsp_valid,
  output logic [1:0]     rsp_kind,
  output logic [DW-1:0]  rsp_data,
  output logic [AW:0]    rsp_rdptr,
  output logic [AW:0]    rsp_wrptr,
  output logic           irq
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rd_ptr_w, wr_ptr_w, rd_nxt_w, wr_nxt_w, fill_w;
  logic [DW-1:0] head_w;
  logic          ovf_w, pop_w, ovf_clr_w, emit_w;

  evq_store #(.DW(DW), .AW(AW)) store_i (
    .clk(clk), .rst_n(rst_n),
    .push_i(evt_valid), .data_i(evt_data), .pop_i(pop_w), .ovf_clr_i(ovf_clr_w),
    .rd_ptr_o(rd_ptr_w), .wr_ptr_o(wr_ptr_w), .rd_nxt_o(rd_nxt_w), .wr_nxt_o(wr_nxt_w),
    .fill_o(fill_w), .head_o(head_w), .ovf_o(ovf_w)
  );

  evq_reader #(.DW(DW), .PW(PW), .CW(CW), .MAXB(MAXB), .CSW(CSW)) reader_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_burst_i(cmd_burst), .cmd_count_i(cmd_count),
    .fill_i(fill_w), .head_i(head_w), .ovf_i(ovf_w), .chan_state_i(chan_state),
    .rd_nxt_i(rd_nxt_w), .wr_nxt_i(wr_nxt_w),
    .pop_o(pop_w), .ovf_clr_o(ovf_clr_w), .emit_o(emit_w),
    .rsp_valid_o(rsp_valid), .rsp_kind_o(rsp_kind), .rsp_data_o(rsp_data),
    .rsp_rdptr_o(rsp_rdptr), .rsp_wrptr_o(rsp_wrptr)
  );

  evq_irq #(.PW(PW)) irq_i (
    .clk(clk), .rst_n(rst_n), .load_i(emit_w),
    .wr_nxt_i(wr_nxt_w), .wr_ptr_i(wr_ptr_w), .irq_o(irq)
  );
endmodule

// File: rtl/evq_hostread_chk.sv
module evq_hostread_chk #(
  parameter int DW   = 32,
  parameter int AW   = 4,
  parameter int MAXB = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          evt_valid,
  input logic          rsp_valid,
  input logic [1:0]    rsp_kind,
  input logic [DW-1:0] rsp_data,
  input logic [AW:0]   rsp_rdptr,
  input logic [AW:0]   rsp_wrptr,
  input logic          irq,
  input logic [AW:0]   rd_ptr,
  input logic [AW:0]   wr_ptr,
  input logic          ovf
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] lvl;
  assign lvl = wr_ptr - rd_ptr;

  p_status_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == 2'd1) |-> (rsp_rdptr == rsp_wrptr));

  p_rd_moves_only_on_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ptr != $past(rd_ptr)) |-> (rsp_valid && rsp_kind[0] == (rsp_kind == 2'd3) && rsp_rdptr == rd_ptr));

  p_wr_report_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_wrptr == wr_ptr));

  p_fill_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= PW'(DEPTH));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && lvl == PW'(DEPTH)) |=> ovf);

  p_hdr_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == 2'd2) |-> (rsp_data <= DW'(MAXB)));

  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !irq);
endmodule

bind evq_hostread evq_hostread_chk #(.DW(DW), .AW(AW), .MAXB(MAXB)) chk_i (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid),
  .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_data(rsp_data),
  .rsp_rdptr(rsp_rdptr), .rsp_wrptr(rsp_wrptr), .irq(irq),
  .rd_ptr(rd_ptr_w), .wr_ptr(wr_ptr_w), .ovf(ovf_w)
);

// File: tb/evq_hostread_tb_top.sv
module evq_hostread_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        evt_valid;
  logic [31:0] evt_data;
  logic [7:0]  chan_state;
  logic        cmd_valid, cmd_burst;
  logic [3:0]  cmd_count;
  logic        rsp_valid, irq;
  logic [1:0]  rsp_kind;
  logic [31:0] rsp_data;
  logic [4:0]  rsp_rdptr, rsp_wrptr;

  int checks = 0;
  int errs   = 0;
  logic [31:0] mq [32];
  int mrd = 0, mwr = 0;
  logic movf = 1'b0;

  evq_hostread dut_i (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_data(evt_data),
    .chan_state(chan_state), .cmd_valid(cmd_valid), .cmd_burst(cmd_burst),
    .cmd_count(cmd_count), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
    .rsp_data(rsp_data), .rsp_rdptr(rsp_rdptr), .rsp_wrptr(rsp_wrptr), .irq(irq)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic        is_rd;
    logic [31:0] wdata;
    logic [1:0]  kind;
    logic [31:0] data;
    logic [4:0]  rp;
    logic [4:0]  wp;
    logic        irq;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 32'h0,        2'd1, 32'h0000005A, 5'd0, 5'd0, 1'b0},
    '{1'b0, 32'h11111111, 2'd0, 32'h0,        5'd0, 5'd0, 1'b1},
    '{1'b0, 32'h22222222, 2'd0, 32'h0,        5'd0, 5'd0, 1'b1},
    '{1'b1, 32'h0,        2'd0, 32'h11111111, 5'd1, 5'd2, 1'b0},
    '{1'b0, 32'h33333333, 2'd0, 32'h0,        5'd0, 5'd0, 1'b1},
    '{1'b1, 32'h0,        2'd0, 32'h22222222, 5'd2, 5'd3, 1'b0},
    '{1'b1, 32'h0,        2'd0, 32'h33333333, 5'd3, 5'd3, 1'b0},
    '{1'b1, 32'h0,        2'd1, 32'h0000005A, 5'd3, 5'd3, 1'b0}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(logic [31:0] d);
    @(negedge clk);
    evt_valid = 1'b1;
    evt_data  = d;
    @(negedge clk);
    evt_valid = 1'b0;
    if (mwr - mrd < 16) begin
      mq[mwr % 32] = d;
      mwr++;
    end else begin
      movf = 1'b1;
    end
  endtask

  // single read checked against the bench model
  task automatic single_read(string tag);
    logic [31:0] ed;
    logic [1:0]  ek;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_burst = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (mwr != mrd) begin
      ek = 2'd0;
      ed = mq[mrd % 32];
      mrd++;
    end else begin
      ek = 2'd1;
      ed = {movf, 23'd0, chan_state};
      movf = 1'b0;
    end
    chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " kind"}, 32'(rsp_kind), 32'(ek));
    chk({tag, " data"}, rsp_data, ed);
    chk("R3 rdptr", 32'(rsp_rdptr), 32'(mrd % 32));
    chk("R3 wrptr", 32'(rsp_wrptr), 32'(mwr % 32));
    chk("R9 irq low after response", 32'(irq), 32'd0);
  endtask

  task automatic burst(logic [3:0] n, bit intrude);
    int m;
    m = (n > 8) ? 8 : int'(n);
    if (mwr - mrd < m) m = mwr - mrd;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_burst = 1'b1;
    cmd_count = n;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R7 header kind", 32'(rsp_kind), 32'd2);
    chk("R7 header count", rsp_data, 32'(m));
    chk("R7 header rdptr", 32'(rsp_rdptr), 32'(mrd % 32));
    if (intrude) begin
      cmd_valid = 1'b1;
      cmd_burst = 1'b0;
    end
    for (int i = 0; i < m; i++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R7 entry valid", 32'(rsp_valid), 32'd1);
      chk("R7 entry kind", 32'(rsp_kind), 32'd3);
      chk("R7 entry data order", rsp_data, mq[mrd % 32]);
      mrd++;
      chk("R7 entry rdptr", 32'(rsp_rdptr), 32'(mrd % 32));
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(intrude ? "R8 no response after burst" : "R7 burst ends", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    #(8 * 150000);
    errs++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    rst_n = 1'b0; evt_valid = 1'b0; evt_data = '0; chan_state = 8'h5A;
    cmd_valid = 1'b0; cmd_burst = 1'b0; cmd_count = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R10 irq", 32'(irq), 32'd0);
    chk("R10 rdptr", 32'(rsp_rdptr), 32'd0);
    chk("R10 wrptr", 32'(rsp_wrptr), 32'd0);

    // table walk: interleaved pushes and single reads (R1 R2 R3 R9)
    foreach (VECS[i]) begin
      if (VECS[i].is_rd) begin
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_burst = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (mwr != mrd) mrd++;
        chk("R1 valid", 32'(rsp_valid), 32'd1);
        chk(VECS[i].kind == 2'd1 ? "R2 kind" : "R1 kind", 32'(rsp_kind), 32'(VECS[i].kind));
        chk(VECS[i].kind == 2'd1 ? "R2 status word" : "R1 event data", rsp_data, VECS[i].data);
        chk("R3 rdptr", 32'(rsp_rdptr), 32'(VECS[i].rp));
        chk("R3 wrptr", 32'(rsp_wrptr), 32'(VECS[i].wp));
      end else begin
        push(VECS[i].wdata);
      end
      chk("R9 irq", 32'(irq), 32'(VECS[i].irq));
    end

    // fill to 16 and offer one more (R4 R5)
    for (int i = 0; i < 16; i++) push(32'hA000_0000 + 32'(i));
    chk("R9 irq after pushes", 32'(irq), 32'd1);
    push(32'hDEAD_BEEF);
    chk("R5 overflow drop keeps irq", 32'(irq), 32'd1);
    // burst above limit with intruding command (R7 R8)
    burst(4'd12, 1'b1);
    burst(4'd8, 1'b0);
    // burst above fill level, then on empty queue (R7)
    for (int i = 0; i < 3; i++) push(32'hB000_0000 + 32'(i));
    burst(4'd5, 1'b0);
    burst(4'd3, 1'b0);
    // sticky overflow in status, then cleared (R2 R6)
    single_read("R6 status shows overflow");
    chan_state = 8'h3C;
    single_read("R6 status overflow cleared");
    // pointer wrap, order preserved (R4)
    for (int i = 0; i < 12; i++) push(32'hC000_0000 + 32'(i));
    for (int i = 0; i < 12; i++) single_read("R4 wrap order");
    single_read("R2 empty after wrap");

    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule